// File: doc/BRIEF.md
# Frame capture buffer with SPI register access

This block holds one image frame in an internal byte memory and exposes it to a host through an SPI slave port. The host arms a capture by writing a control register. The capture engine waits for the next rising edge of the frame-sync input. It then stores every pixel byte accepted on the pixel interface until the following frame-sync rising edge, and raises a done flag. The host polls a status register until that flag is set. It reads the stored byte count from three count registers and then pulls the frame out with a streaming burst command or with single-byte reads.

The pixel interface, frame sync and SPI sampling all run on the one system clock `clk`. The SPI lines are passed through a short synchronizer and oversampled, so SCLK must stay at least four `clk` periods high and four low. SPI is mode 0, MSB first. Each access sits inside one chip-select window. The first byte is an address whose bit 7 selects write (1) or read (0). The second byte carries the data. On the pixel side, `pix_ready` is held high at all times and the block never applies back-pressure. A byte offered while the engine is not capturing, or once the memory is full, is accepted and discarded.

Three general-purpose bits are plain storage: a direction field, an output value field and an input readback. They drive and sample the sensor's reset (bit 0), power-down (bit 1) and power-enable (bit 2) lines.

Top module: `fbuf_spi_capture`

## Requirements
- R1: After reset, `gpio_oe` and `gpio_out` are 0, `pix_ready` is 1, the stored count reads 0, and status register 0x41 reads 0x00 while `pix_fsync` is low.
- R2: A transaction whose address byte has bit 7 set stores the second byte into the register named by bits 6:0. Bits 2:0 of register 0x05 drive `gpio_oe` and read back from 0x05. Bits 2:0 of register 0x06 drive `gpio_out` and read back from 0x06. The upper five bits of both read as 0.
- R3: A transaction whose address byte has bit 7 clear returns the register contents, MSB first, during the second byte. MISO changes after SCLK falls and is sampled by the host before SCLK rises. Register 0x40 returns the parameter `VERSION`.
- R4: Register 0x45 returns the synchronized `gpio_in` value in bits 2:0, with zero above.
- R5: Writes to undefined addresses, and to the read-only addresses 0x40 to 0x45, change nothing. Reads of undefined addresses, and of the write-only control register 0x04, return 0x00.
- R6: Writing control register 0x04 with bit 1 set arms a capture and clears the done flag, the count and both memory positions. Capture starts at the next rising edge of `pix_fsync` and stops at the following one. Status 0x41 reports the registered frame-sync level in bit 0, capture in progress in bit 1 and done in bit 3.
- R7: The count of stored bytes reads from 0x42 (bits 7:0), 0x43 (bits 15:8) and 0x44 (bits 22:16, with bit 7 always 0). Bytes beyond `DEPTH` are dropped and the count stops at `DEPTH`. Bytes offered outside a capture are not stored.
- R8: Writing 0x04 with bit 0 set clears the done flag.
- R9: Command byte 0x3C streams memory bytes, one per further byte clocked under chip select, and advances the read position after each one. The first such burst after a capture is armed returns one 0x00 dummy byte before the data. Later bursts continue from the current position with no dummy.
- R10: Command byte 0x3D returns the byte at the read position during the second byte and advances the position by one.
- R11: Writing 0x04 with bit 5 set returns the read position to byte 0.
- R12: Writing 0x04 with bit 4 set returns the write position and the count to 0.
- R13: Raising chip select in the middle of a byte discards that byte. A data byte that is cut short does not advance the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| pix_fsync | input | 1 | Frame-sync level, synchronous to clk |
| pix_valid | input | 1 | Pixel byte offered this cycle |
| pix_data | input | 8 | Pixel byte |
| pix_ready | output | 1 | Always 1; the block never stalls the pixel source |
| gpio_in | input | 3 | Sensor control line readback (reset, power-down, power-enable) |
| gpio_oe | output | 3 | Direction register bits 2:0 |
| gpio_out | output | 3 | Output value register bits 2:0 |

## Verification
A read position that drifts by even one byte shows as a shifted stream on the very next 0x3C or 0x3D access. The bench compares every returned byte against a computed pattern, so such a slip is seen at once. A wrong dummy decision shows the same way, as a stream offset by one byte from its first data byte. A write position or count that keeps moving outside a capture shows up in the three count registers read straight after the frame ends and again after stray pixel bytes. A capture engine stuck in the wrong phase shows in status bits 1 and 3 on the next poll.

// File: rtl/fbuf_cap_pkg.sv
package fbuf_cap_pkg;
  localparam logic [6:0] ADDR_FIFO_CTL = 7'h04;
  localparam logic [6:0] ADDR_GPIO_DIR = 7'h05;
  localparam logic [6:0] ADDR_GPIO_OUT = 7'h06;
  localparam logic [6:0] ADDR_VERSION  = 7'h40;
  localparam logic [6:0] ADDR_STATUS   = 7'h41;
  localparam logic [6:0] ADDR_CNT_LO   = 7'h42;
  localparam logic [6:0] ADDR_CNT_MID  = 7'h43;
  localparam logic [6:0] ADDR_CNT_HI   = 7'h44;
  localparam logic [6:0] ADDR_GPIO_IN  = 7'h45;

  localparam logic [7:0] OP_STREAM = 8'h3C;
  localparam logic [7:0] OP_SINGLE = 8'h3D;

  localparam int CTL_CLR_DONE = 0;
  localparam int CTL_ARM      = 1;
  localparam int CTL_WR_RST   = 4;
  localparam int CTL_RD_RST   = 5;

  localparam int GPIO_W    = 3;
  localparam int COUNT_W   = 23;

  typedef enum logic [2:0] {
    XF_NONE, XF_READ, XF_WRITE, XF_STREAM, XF_SINGLE
  } xfer_kind_t;

  typedef enum logic [1:0] {
    CAP_IDLE, CAP_ARMED, CAP_RUN
  } cap_phase_t;
endpackage

// File: rtl/fbuf_spi_port.sv
module fbuf_spi_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       sel,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  input  logic [7:0] tx_byte
);
  logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
  logic sclk_s, cs_s, mosi_s, sclk_d;
  logic sclk_rise, sclk_fall;
  logic [2:0] bit_cnt;
  logic [6:0] shift_in;
  logic [7:0] shift_out;
  logic       had_byte;

  assign sclk_s    = sclk_sr[SYNC_STAGES-1];
  assign cs_s      = cs_sr[SYNC_STAGES-1];
  assign mosi_s    = mosi_sr[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign miso      = shift_out[7];
  assign sel       = ~cs_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_sr <= '0; cs_sr <= '1; mosi_sr <= '0;
        end else begin
          sclk_sr <= sclk; cs_sr <= cs_n; mosi_sr <= mosi;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_sr <= '0; cs_sr <= '1; mosi_sr <= '0;
        end else begin
          sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
          cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
          mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      shift_in  <= '0;
      shift_out <= '0;
      had_byte  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      rx_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt   <= '0;
        had_byte  <= 1'b0;
        shift_out <= '0;
      end else begin
        if (sclk_rise) begin
          shift_in <= {shift_in[5:0], mosi_s};
          bit_cnt  <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_byte  <= {shift_in, mosi_s};
            had_byte <= 1'b1;
          end
        end
        if (sclk_fall) begin
          if (bit_cnt == 3'd0 && had_byte) shift_out <= tx_byte;
          else                             shift_out <= {shift_out[6:0], 1'b0};
        end
      end
    end
  end

  // R13: a raised chip select leaves no partial byte behind
  assert_cs_abort_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == 3'd0 && !had_byte));
  // R3: the reply line is quiet while deselected
  assert_miso_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso);
endmodule

// File: rtl/fbuf_capture.sv
module fbuf_capture
  import fbuf_cap_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          pix_valid,
  input  logic [7:0]    pix_data,
  input  logic          arm,
  input  logic          clr_done,
  input  logic          wr_rst,
  input  logic          rd_rst,
  input  logic          rd_adv,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          done,
  output logic          busy,
  output logic          vsync
);
  logic [7:0] mem [DEPTH];
  cap_phase_t phase;
  logic fsync_q, fsync_rise, room, wr_en;
  logic [AW-1:0] wr_pos, rd_pos;

  assign fsync_rise = fsync & ~fsync_q;
  assign room       = count < CW'(DEPTH);
  assign wr_en      = (phase == CAP_RUN) && !fsync_rise && pix_valid && room;
  assign rd_data    = mem[rd_pos];
  assign busy       = (phase == CAP_RUN);
  assign vsync      = fsync_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_pos] <= pix_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q <= 1'b0;
      phase   <= CAP_IDLE;
      done    <= 1'b0;
      count   <= '0;
      wr_pos  <= '0;
      rd_pos  <= '0;
    end else begin
      fsync_q <= fsync;
      case (phase)
        CAP_ARMED: if (fsync_rise) phase <= CAP_RUN;
        CAP_RUN: begin
          if (fsync_rise) begin
            phase <= CAP_IDLE;
            done  <= 1'b1;
          end else if (wr_en) begin
            wr_pos <= wr_pos + 1'b1;
            count  <= count + 1'b1;
          end
        end
        default: ;
      endcase
      if (clr_done) done <= 1'b0;
      if (wr_rst) begin
        wr_pos <= '0;
        count  <= '0;
      end
      if (rd_adv) rd_pos <= rd_pos + 1'b1;
      if (rd_rst) rd_pos <= '0;
      if (arm) begin
        phase  <= CAP_ARMED;
        done   <= 1'b0;
        wr_pos <= '0;
        count  <= '0;
        rd_pos <= '0;
      end
    end
  end

  assert_count_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != CAP_RUN && !arm && !wr_rst) |=> $stable(count));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == CAP_IDLE);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv && !rd_rst && !arm) |=> $stable(rd_pos));
endmodule

// File: rtl/fbuf_regs.sv
module fbuf_regs
  import fbuf_cap_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h5A,
  parameter int CW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  input  logic [CW-1:0]     count,
  input  logic              done,
  input  logic              busy,
  input  logic              vsync,
  input  logic [7:0]        buf_data,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic              arm,
  output logic              clr_done,
  output logic              wr_rst,
  output logic              rd_rst,
  output logic              rd_adv,
  output logic [GPIO_W-1:0] gpio_oe,
  output logic [GPIO_W-1:0] gpio_out
);
  xfer_kind_t kind;
  logic [1:0] nbytes;
  logic [6:0] addr;
  logic dummy_due, fresh_frame;
  logic [GPIO_W-1:0] gin_s1, gin_s2;
  logic [COUNT_W-1:0] cnt_ext;
  logic [7:0] reg_val;

  assign cnt_ext = COUNT_W'(count);

  always_comb begin
    case (addr)
      ADDR_GPIO_DIR: reg_val = 8'(gpio_oe);
      ADDR_GPIO_OUT: reg_val = 8'(gpio_out);
      ADDR_VERSION:  reg_val = VERSION;
      ADDR_STATUS:   reg_val = {4'b0, done, 1'b0, busy, vsync};
      ADDR_CNT_LO:   reg_val = cnt_ext[7:0];
      ADDR_CNT_MID:  reg_val = cnt_ext[15:8];
      ADDR_CNT_HI:   reg_val = {1'b0, cnt_ext[22:16]};
      ADDR_GPIO_IN:  reg_val = 8'(gin_s2);
      default:       reg_val = 8'h00;
    endcase
  end

  always_comb begin
    case (kind)
      XF_READ:   tx_byte = (nbytes == 2'd1) ? reg_val : 8'h00;
      XF_STREAM: tx_byte = dummy_due ? 8'h00 : buf_data;
      XF_SINGLE: tx_byte = (nbytes == 2'd1) ? buf_data : 8'h00;
      default:   tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gin_s1 <= '0;
      gin_s2 <= '0;
    end else begin
      gin_s1 <= gpio_in;
      gin_s2 <= gin_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind        <= XF_NONE;
      nbytes      <= '0;
      addr        <= '0;
      dummy_due   <= 1'b0;
      fresh_frame <= 1'b0;
      arm         <= 1'b0;
      clr_done    <= 1'b0;
      wr_rst      <= 1'b0;
      rd_rst      <= 1'b0;
      rd_adv      <= 1'b0;
      gpio_oe     <= '0;
      gpio_out    <= '0;
    end else begin
      arm      <= 1'b0;
      clr_done <= 1'b0;
      wr_rst   <= 1'b0;
      rd_rst   <= 1'b0;
      rd_adv   <= 1'b0;
      if (!sel) begin
        kind      <= XF_NONE;
        nbytes    <= '0;
        dummy_due <= 1'b0;
      end else if (rx_valid) begin
        if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
        if (nbytes == 2'd0) begin
          addr <= rx_byte[6:0];
          if (rx_byte[7])                kind <= XF_WRITE;
          else if (rx_byte == OP_STREAM) begin
            kind      <= XF_STREAM;
            dummy_due <= fresh_frame;
          end
          else if (rx_byte == OP_SINGLE) kind <= XF_SINGLE;
          else                           kind <= XF_READ;
        end else begin
          case (kind)
            XF_WRITE: if (nbytes == 2'd1) begin
              case (addr)
                ADDR_FIFO_CTL: begin
                  clr_done <= rx_byte[CTL_CLR_DONE];
                  arm      <= rx_byte[CTL_ARM];
                  wr_rst   <= rx_byte[CTL_WR_RST];
                  rd_rst   <= rx_byte[CTL_RD_RST];
                  if (rx_byte[CTL_ARM]) fresh_frame <= 1'b1;
                end
                ADDR_GPIO_DIR: gpio_oe  <= rx_byte[GPIO_W-1:0];
                ADDR_GPIO_OUT: gpio_out <= rx_byte[GPIO_W-1:0];
                default: ;
              endcase
            end
            XF_STREAM: begin
              if (dummy_due) begin
                dummy_due   <= 1'b0;
                fresh_frame <= 1'b0;
              end else begin
                rd_adv <= 1'b1;
              end
            end
            XF_SINGLE: if (nbytes == 2'd1) rd_adv <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assert_gpio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rx_valid) |=> ($stable(gpio_out) && $stable(gpio_oe)));
  assert_dummy_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_due |-> kind == XF_STREAM);
  assert_no_adv_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rd_adv || $past(rx_valid));
endmodule

// File: rtl/fbuf_spi_capture.sv
module fbuf_spi_capture
  import fbuf_cap_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter logic [7:0] VERSION = 8'h5A,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic        pix_fsync,
  input  logic        pix_valid,
  input  logic [7:0]  pix_data,
  output logic        pix_ready,
  input  logic [2:0]  gpio_in,
  output logic [2:0]  gpio_oe,
  output logic [2:0]  gpio_out
);
  localparam int CW = $clog2(DEPTH + 1);

  logic sel, rx_valid;
  logic [7:0] rx_byte, tx_byte, buf_data;
  logic arm, clr_done, wr_rst, rd_rst, rd_adv;
  logic done, busy, vsync;
  logic [CW-1:0] count;

  assign pix_ready = 1'b1;

  fbuf_spi_port #(.SYNC_STAGES(SYNC_STAGES)) spi_i (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso), .sel(sel), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte)
  );

  fbuf_regs #(.VERSION(VERSION), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .count(count), .done(done),
    .busy(busy), .vsync(vsync), .buf_data(buf_data), .gpio_in(gpio_in),
    .arm(arm), .clr_done(clr_done), .wr_rst(wr_rst), .rd_rst(rd_rst),
    .rd_adv(rd_adv), .gpio_oe(gpio_oe), .gpio_out(gpio_out)
  );

  fbuf_capture #(.DEPTH(DEPTH)) cap_i (
    .clk(clk), .rst_n(rst_n), .fsync(pix_fsync), .pix_valid(pix_valid),
    .pix_data(pix_data), .arm(arm), .clr_done(clr_done), .wr_rst(wr_rst),
    .rd_rst(rd_rst), .rd_adv(rd_adv), .rd_data(buf_data), .count(count),
    .done(done), .busy(busy), .vsync(vsync)
  );
endmodule

// File: tb/fbuf_spi_capture_tb.sv
module fbuf_spi_capture_tb_top;
  localparam int DEPTH = 64;
  localparam logic [7:0] VER = 8'hC3;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic pix_fsync = 1'b0, pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic pix_ready;
  logic [2:0] gpio_in = '0;
  logic [2:0] gpio_oe, gpio_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fbuf_spi_capture #(.DEPTH(DEPTH), .VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .pix_fsync(pix_fsync),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_out(gpio_out)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] d;
    cs_low();
    spi_byte({1'b1, a}, d);
    spi_byte(v, d);
    cs_high();
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] d;
    cs_low();
    spi_byte(a, d);
    spi_byte(8'h00, v);
    cs_high();
  endtask

  task automatic read_count(output int c);
    logic [7:0] b0, b1, b2;
    reg_rd(8'h42, b0);
    reg_rd(8'h43, b1);
    reg_rd(8'h44, b2);
    check("R7 count hi bit7", 32'(b2[7]), 32'd0);
    c = int'({b2[6:0], b1, b0});
  endtask

  task automatic push_pixels(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data = pat(base + k);
      if (k % 3 == 2) begin
        @(negedge clk);
        pix_valid = 1'b0;
      end
    end
    @(negedge clk) pix_valid = 1'b0;
  endtask

  task automatic push_junk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data = 8'hEE;
    end
    @(negedge clk) pix_valid = 1'b0;
  endtask

  task automatic fsync_pulse();
    @(negedge clk) pix_fsync = 1'b1;
    @(negedge clk) pix_fsync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // stream: optional dummy then n bytes expected as pat(base+k)
  task automatic stream(input bit dummy, input int base, input int n, input string req);
    logic [7:0] d;
    cs_low();
    spi_byte(8'h3C, d);
    if (dummy) begin
      spi_byte(8'h00, d);
      check({req, " dummy"}, 32'(d), 32'h00);
    end
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, d);
      check(req, 32'(d), 32'(pat(base + k)));
    end
    cs_high();
  endtask

  task automatic single(input int idx, input string req);
    logic [7:0] d;
    reg_rd(8'h3D, d);
    check(req, 32'(d), 32'(pat(idx)));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] d;
    int c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 gpio_oe", 32'(gpio_oe), 0);
    check("R1 gpio_out", 32'(gpio_out), 0);
    check("R1 pix_ready", 32'(pix_ready), 1);
    reg_rd(8'h41, v); check("R1 status", 32'(v), 0);
    read_count(c); check("R1 count", c, 0);

    // R3 version and vsync bit of R6
    reg_rd(8'h40, v); check("R3 version", 32'(v), 32'(VER));
    @(negedge clk) pix_fsync = 1'b1;
    reg_rd(8'h41, v); check("R6 vsync bit", 32'(v), 32'h01);
    @(negedge clk) pix_fsync = 1'b0;
    repeat (3) @(negedge clk);

    // R2 sweep of GPIO storage
    for (int i = 0; i < 8; i++) begin
      reg_wr(7'h05, 8'(8'hF8 | i));
      check("R2 gpio_oe", 32'(gpio_oe), i);
      reg_rd(8'h05, v); check("R2 dir readback", 32'(v), i);
      reg_wr(7'h06, 8'(8'hF8 | (7 - i)));
      check("R2 gpio_out", 32'(gpio_out), 7 - i);
      reg_rd(8'h06, v); check("R2 out readback", 32'(v), 7 - i);
    end
    // R4 input readback sweep
    for (int i = 0; i < 8; i++) begin
      gpio_in = 3'(i);
      reg_rd(8'h45, v); check("R4 gpio_in", 32'(v), i);
    end

    // R5 undefined and read-only addresses
    reg_wr(7'h10, 8'hFF);
    reg_rd(8'h10, v); check("R5 undefined read", 32'(v), 0);
    reg_wr(7'h40, 8'h00);
    reg_rd(8'h40, v); check("R5 version kept", 32'(v), 32'(VER));
    reg_wr(7'h45, 8'h07);
    reg_wr(7'h44, 8'h7F);
    check("R5 gpio_oe kept", 32'(gpio_oe), 7);
    check("R5 gpio_out kept", 32'(gpio_out), 0);
    read_count(c); check("R5 count kept", c, 0);
    reg_rd(8'h3B, v); check("R5 undefined 3B", 32'(v), 0);
    reg_rd(8'h04, v); check("R5 ctl reads zero", 32'(v), 0);

    // R6 capture: junk before arm, junk while armed
    push_junk(3);
    reg_wr(7'h04, 8'h02);
    push_junk(5);
    reg_rd(8'h41, v); check("R6 armed status", 32'(v), 0);
    fsync_pulse();
    reg_rd(8'h41, v); check("R6 busy status", 32'(v), 32'h02);
    push_pixels(0, 20);
    fsync_pulse();
    reg_rd(8'h41, v); check("R6 done status", 32'(v), 32'h08);
    read_count(c); check("R7 count 20", c, 20);
    push_junk(4);
    read_count(c); check("R7 no store after frame", c, 20);

    // R9 stream with dummy, then continuation
    stream(1'b1, 0, 10, "R9 first stream");
    stream(1'b0, 10, 5, "R9 second stream");
    // R10 single reads
    single(15, "R10 single");
    // R13 aborted partial byte during stream
    cs_low();
    spi_byte(8'h3C, d);
    spi_bits(8'h00, 3, d);
    cs_high();
    single(16, "R13 abort no advance");
    // R13 aborted address byte
    cs_low();
    spi_bits(8'h86, 5, d);
    cs_high();
    check("R13 partial write dropped", 32'(gpio_out), 0);
    // R11 read position reset
    reg_wr(7'h04, 8'h20);
    stream(1'b0, 0, 3, "R11 rd reset");
    // R8 clear done
    reg_wr(7'h04, 8'h01);
    reg_rd(8'h41, v); check("R8 done cleared", 32'(v), 0);
    read_count(c); check("R8 count unchanged", c, 20);

    // R7 saturation
    reg_wr(7'h04, 8'h02);
    fsync_pulse();
    push_pixels(100, DEPTH + 6);
    fsync_pulse();
    read_count(c); check("R7 saturated count", c, DEPTH);
    stream(1'b1, 100, DEPTH, "R7 R9 full frame");
    // R12 write position reset
    reg_wr(7'h04, 8'h10);
    read_count(c); check("R12 count reset", c, 0);
    reg_rd(8'h41, v); check("R12 done kept", 32'(v), 32'h08);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule